// File: doc/BRIEF.md
# Concurrent round-robin dispatch matcher

This block is the dispatch scheduler for one first-stage module of a three-stage Clos switch whose middle stage holds no buffers. The module holds one virtual output queue (VOQ) for each destination port of the switch. It sees one occupancy bit per VOQ and must decide, once per cell slot, which VOQ may put a cell on each of its links towards the central stage. Queue number `v = h*N_MOD + j` stands for output module `j`, port `h`. The output module therefore varies fastest across neighbouring queues.

A slot starts with `start_i`. The occupancy vector is then frozen, and a fixed number of match rounds runs, one per clock. In each round, every free link grants one eligible queue, and every queue that holds grants accepts one of them. Both choices use round-robin pointers. When the rounds are done, every matched link raises a request towards the central module it is wired to, tagged with the destination output module. The central-stage grants come back on `cm_gnt_i`, and the block then reports, per link, the queue that sends in the next slot. A pointer moves only when its match was made in the first round and the central stage granted it. A request that is refused is therefore retried from the same pointers.

Top module: `crrd_dispatch`

## Requirements
- R1: After reset, `busy_o`, `match_done_o`, `lreq_valid_o` and `send_valid_o` are all 0. Every link pointer and every queue pointer is 0.
- R2: `match_done_o` is high for exactly one cycle. That cycle comes `N_ITER` clocks after the clock edge that samples `start_i` in the idle state.
- R3: In each round, every occupied, still unmatched queue is offered to every still free link. Each free link picks the first offered queue, searching upward from its own pointer and wrapping from `N_PORT*N_MOD-1` to 0.
- R4: A queue that holds grants accepts the first granting link, searching upward from its own pointer and wrapping from `N_LINK-1` to 0.
- R5: A later round involves only queues and links left unmatched by earlier rounds. A match made in an earlier round is never changed within the slot. After `N_ITER` rounds the match stands even if it is not maximal.
- R6: An empty queue is never matched. No queue is matched to more than one link. A link left unmatched raises no request (`lreq_valid_o` bit 0).
- R7: For a matched link `l`, `lreq_voq_o[l]` is the matched queue `v`, and `lreq_om_o[l]` is `v mod N_MOD`.
- R8: When `cm_gnt_valid_i` is high while the block waits for grants, the block sets `send_valid_o[l] = lreq_valid_o[l] & cm_gnt_i[l]` and `send_voq_o[l]` to the matched queue. It then holds both until the next accepted `start_i`, which clears `send_valid_o`.
- R9: On a central grant to a link whose match was made in round 0, the link pointer becomes (queue+1) mod queue count, and that queue's pointer becomes (link+1) mod `N_LINK`. All other pointers keep their values. A refused request therefore repeats its match in the next slot.
- R10: Take `N_PORT=N_LINK=N_MOD=2` with one round, two modules with all queues occupied, round-robin central arbiters and all pointers starting at 0. The switch then sends 1 cell in slot 0, 3 cells in slot 1, and 4 cells in every later slot.
- R11: `start_i` is ignored while the block is busy, and `cm_gnt_valid_i` is ignored while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a slot's match |
| nonempty_i | input | N_PORT*N_MOD | Queue occupancy, sampled with start |
| cm_gnt_valid_i | input | 1 | Central-stage grants present |
| cm_gnt_i | input | N_LINK | Central grant per link |
| busy_o | output | 1 | Slot in progress |
| match_done_o | output | 1 | One-cycle strobe: match complete |
| lreq_valid_o | output | N_LINK | Link request to its central module |
| lreq_om_o | output | N_LINK*KW | Destination output module per link |
| lreq_voq_o | output | N_LINK*VW | Matched queue per link |
| send_valid_o | output | N_LINK | Link sends a cell next slot |
| send_voq_o | output | N_LINK*VW | Queue that sends on each link |

## Verification
One bench instance runs two match rounds per slot. It is fed every one of the 16 occupancy patterns, crossed with all four grant patterns. The sweep separates first-round matches from second-round matches, and moved pointers from frozen ones, because the pointer state carries over from slot to slot. A second pair of instances forms a two-module switch with full queues, with central arbiters modelled in the bench. This pair shows the slot-by-slot rise from 1 to 4 cells that comes from the pointers spreading apart. A run of fully occupied slots with all grants refused shows that the retry repeats the same match. Extra start and grant pulses at the wrong moments show they have no effect.

// File: rtl/crrd_pkg.sv
package crrd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} crrd_state_e;

  function automatic int unsigned clog2_min1(input int unsigned x);
    return (x > 1) ? $clog2(x) : 1;
  endfunction
endpackage

// File: rtl/crrd_rr_arb.sv
module crrd_rr_arb #(
  parameter int unsigned W  = 4,
  parameter int unsigned PW = 2
) (
  input  logic [W-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic [W-1:0]  gnt_o,
  output logic [PW-1:0] idx_o,
  output logic          any_o
);
  logic [PW-1:0] pos;
  int unsigned   sum;
  logic          hit;

  // first request at or after ptr_i, wrapping
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    hit   = 1'b0;
    pos   = '0;
    sum   = 0;
    for (int i = 0; i < W; i++) begin
      sum = int'(ptr_i) + i;
      if (sum >= W) sum = sum - W;
      pos = PW'(sum);
      if (!hit && req_i[pos]) begin
        hit        = 1'b1;
        gnt_o[pos] = 1'b1;
        idx_o      = pos;
      end
    end
    any_o = hit;
  end
endmodule

// File: rtl/crrd_im_match.sv
module crrd_im_match #(
  parameter int unsigned NL = 2,
  parameter int unsigned NV = 4,
  parameter int unsigned LW = 1,
  parameter int unsigned VW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   step_i,
  input  logic                   first_i,
  input  logic [NV-1:0]          ne_i,
  input  logic [NL-1:0][VW-1:0]  lptr_i,
  input  logic [NV-1:0][LW-1:0]  vptr_i,
  output logic [NL-1:0]          link_valid_o,
  output logic [NL-1:0][VW-1:0]  link_voq_o,
  output logic [NL-1:0]          link_first_o
);
  logic [NV-1:0]         voq_free_q;
  logic [NL-1:0]         link_valid_q, link_first_q;
  logic [NL-1:0][VW-1:0] link_voq_q;

  logic [NL-1:0][NV-1:0] lgnt;
  logic [NL-1:0][VW-1:0] lidx;
  logic [NL-1:0]         lany;
  logic [NV-1:0][NL-1:0] vacc;
  logic [NV-1:0][LW-1:0] vidx;
  logic [NV-1:0]         vany;
  logic [NL-1:0]         link_hit;

  // grant stage: one arbiter per link over free, occupied queues
  for (genvar l = 0; l < NL; l++) begin : g_link
    logic [NV-1:0] lreq;
    assign lreq = ne_i & voq_free_q & {NV{~link_valid_q[l]}};

    crrd_rr_arb #(.W(NV), .PW(VW)) u_link_arb (
      .req_i (lreq),
      .ptr_i (lptr_i[l]),
      .gnt_o (lgnt[l]),
      .idx_o (lidx[l]),
      .any_o (lany[l])
    );

    // matched when the granted queue accepts this link
    assign link_hit[l] = lany[l] & vacc[lidx[l]][l];

    AST_GNT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |-> ((lgnt[l] & ~ne_i) == '0)); // R6
    AST_LINK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_valid_q[l] && !clear_i) |=> (link_valid_q[l] && $stable(link_voq_q[l]))); // R5
  end

  // accept stage: one arbiter per queue over the grants it holds
  for (genvar v = 0; v < NV; v++) begin : g_voq
    logic [NL-1:0] rcv;
    logic [NL-1:0] owner;
    always_comb begin
      for (int l = 0; l < NL; l++) begin
        rcv[l]   = lgnt[l][v];
        owner[l] = link_valid_q[l] && (link_voq_q[l] == VW'(v));
      end
    end

    crrd_rr_arb #(.W(NL), .PW(LW)) u_voq_arb (
      .req_i (rcv),
      .ptr_i (vptr_i[v]),
      .gnt_o (vacc[v]),
      .idx_o (vidx[v]),
      .any_o (vany[v])
    );

    AST_ACC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(vacc[v])); // R4
    AST_ACC_LINKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && vany[v]) |-> (link_hit[vidx[v]] && lidx[vidx[v]] == VW'(v))); // R4
    AST_VOQ_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owner)); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      voq_free_q   <= '1;
      link_valid_q <= '0;
      link_first_q <= '0;
      link_voq_q   <= '0;
    end else if (clear_i) begin
      voq_free_q   <= '1;
      link_valid_q <= '0;
      link_first_q <= '0;
      link_voq_q   <= '0;
    end else if (step_i) begin
      voq_free_q <= voq_free_q & ~vany;
      for (int l = 0; l < NL; l++) begin
        if (link_hit[l]) begin
          link_valid_q[l] <= 1'b1;
          link_voq_q[l]   <= lidx[l];
          link_first_q[l] <= first_i;
        end
      end
    end
  end

  assign link_valid_o = link_valid_q;
  assign link_voq_o   = link_voq_q;
  assign link_first_o = link_first_q;
endmodule

// File: rtl/crrd_ptr_bank.sv
module crrd_ptr_bank #(
  parameter int unsigned NL = 2,
  parameter int unsigned NV = 4,
  parameter int unsigned LW = 1,
  parameter int unsigned VW = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  upd_i,
  input  logic [NL-1:0]         link_valid_i,
  input  logic [NL-1:0][VW-1:0] link_voq_i,
  input  logic [NL-1:0]         link_first_i,
  input  logic [NL-1:0]         cm_gnt_i,
  output logic [NL-1:0][VW-1:0] lptr_o,
  output logic [NV-1:0][LW-1:0] vptr_o
);
  logic [NL-1:0] take;
  assign take = {NL{upd_i}} & link_valid_i & link_first_i & cm_gnt_i;

  for (genvar l = 0; l < NL; l++) begin : g_lptr
    logic [VW-1:0] lptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lptr_q <= '0;
      else if (take[l])
        lptr_q <= (link_voq_i[l] == VW'(NV - 1)) ? '0 : link_voq_i[l] + 1'b1;
    end
    assign lptr_o[l] = lptr_q;
  end

  for (genvar v = 0; v < NV; v++) begin : g_vptr
    logic [LW-1:0] vptr_q;
    logic          v_take;
    logic [LW-1:0] v_link;
    always_comb begin
      v_take = 1'b0;
      v_link = '0;
      for (int l = 0; l < NL; l++) begin
        if (take[l] && link_voq_i[l] == VW'(v)) begin
          v_take = 1'b1;
          v_link = LW'(l);
        end
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vptr_q <= '0;
      else if (v_take) vptr_q <= (v_link == LW'(NL - 1)) ? '0 : v_link + 1'b1;
    end
    assign vptr_o[v] = vptr_q;
  end

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(lptr_o) && $stable(vptr_o))); // R9
  AST_PTR_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && ((cm_gnt_i & link_valid_i) == '0)) |=> $stable(lptr_o)); // R9
endmodule

// File: rtl/crrd_dispatch.sv
module crrd_dispatch
  import crrd_pkg::*;
#(
  parameter int unsigned N_PORT = 2,
  parameter int unsigned N_LINK = 2,
  parameter int unsigned N_MOD  = 2,
  parameter int unsigned N_ITER = 2,
  localparam int unsigned NV = N_PORT * N_MOD,
  localparam int unsigned VW = clog2_min1(NV),
  localparam int unsigned LW = clog2_min1(N_LINK),
  localparam int unsigned KW = clog2_min1(N_MOD),
  localparam int unsigned IW = clog2_min1(N_ITER)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NV-1:0]          nonempty_i,
  input  logic                   cm_gnt_valid_i,
  input  logic [N_LINK-1:0]      cm_gnt_i,
  output logic                   busy_o,
  output logic                   match_done_o,
  output logic [N_LINK-1:0]      lreq_valid_o,
  output logic [N_LINK*KW-1:0]   lreq_om_o,
  output logic [N_LINK*VW-1:0]   lreq_voq_o,
  output logic [N_LINK-1:0]      send_valid_o,
  output logic [N_LINK*VW-1:0]   send_voq_o
);
  crrd_state_e state_q;
  logic [IW-1:0] iter_q;
  logic [NV-1:0] ne_q;
  logic          done_q;
  logic [N_LINK-1:0]         send_valid_q;
  logic [N_LINK-1:0][VW-1:0] send_voq_q;

  logic [N_LINK-1:0]         link_valid, link_first;
  logic [N_LINK-1:0][VW-1:0] link_voq;
  logic [N_LINK-1:0][VW-1:0] lptr;
  logic [NV-1:0][LW-1:0]     vptr;

  logic accept_start, accept_gnt, last_iter;
  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign accept_gnt   = (state_q == ST_WAIT) && cm_gnt_valid_i;
  assign last_iter    = (iter_q == IW'(N_ITER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      iter_q       <= '0;
      ne_q         <= '0;
      done_q       <= 1'b0;
      send_valid_q <= '0;
      send_voq_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q      <= ST_RUN;
          iter_q       <= '0;
          ne_q         <= nonempty_i;
          send_valid_q <= '0;
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (last_iter) begin
            state_q <= ST_WAIT;
            done_q  <= 1'b1;
          end
        end
        ST_WAIT: if (cm_gnt_valid_i) begin
          state_q      <= ST_IDLE;
          send_valid_q <= link_valid & cm_gnt_i;
          send_voq_q   <= link_voq;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  crrd_im_match #(.NL(N_LINK), .NV(NV), .LW(LW), .VW(VW)) u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (accept_start),
    .step_i       (state_q == ST_RUN),
    .first_i      (iter_q == '0),
    .ne_i         (ne_q),
    .lptr_i       (lptr),
    .vptr_i       (vptr),
    .link_valid_o (link_valid),
    .link_voq_o   (link_voq),
    .link_first_o (link_first)
  );

  crrd_ptr_bank #(.NL(N_LINK), .NV(NV), .LW(LW), .VW(VW)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_i        (accept_gnt),
    .link_valid_i (link_valid),
    .link_voq_i   (link_voq),
    .link_first_i (link_first),
    .cm_gnt_i     (cm_gnt_i),
    .lptr_o       (lptr),
    .vptr_o       (vptr)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign match_done_o = done_q;
  assign lreq_valid_o = (state_q == ST_WAIT) ? link_valid : '0;
  assign send_valid_o = send_valid_q;

  for (genvar l = 0; l < N_LINK; l++) begin : g_out
    assign lreq_om_o[l*KW +: KW]  = KW'(link_voq[l] % N_MOD);
    assign lreq_voq_o[l*VW +: VW] = link_voq[l];
    assign send_voq_o[l*VW +: VW] = send_voq_q[l];

    AST_REQ_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lreq_valid_o[l] |-> ne_q[link_voq[l]]); // R6
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_done_o |=> !match_done_o); // R2
  AST_SEND_MATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_o & ~link_valid) == '0); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i) |=> busy_o); // R11
  AST_IDLE_GNT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && cm_gnt_valid_i) |=> $stable(send_valid_o)); // R11
endmodule

// File: tb/tb_crrd_dispatch.sv
module tb_crrd_dispatch;
  localparam int NP = 2, NL = 2, NM = 2, NV = 4, VW = 2, KW = 1;
  localparam int IT_DUT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // single-module instance, two rounds
  logic          d_start = 0, d_gv = 0;
  logic [NV-1:0] d_ne = '0;
  logic [NL-1:0] d_g = '0;
  logic          d_busy, d_done;
  logic [NL-1:0] d_lv, d_sv;
  logic [NL*KW-1:0] d_lom;
  logic [NL*VW-1:0] d_lvq, d_svq;

  crrd_dispatch #(.N_PORT(NP), .N_LINK(NL), .N_MOD(NM), .N_ITER(IT_DUT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(d_start), .nonempty_i(d_ne),
    .cm_gnt_valid_i(d_gv), .cm_gnt_i(d_g), .busy_o(d_busy), .match_done_o(d_done),
    .lreq_valid_o(d_lv), .lreq_om_o(d_lom), .lreq_voq_o(d_lvq),
    .send_valid_o(d_sv), .send_voq_o(d_svq));

  // two-module switch, one round each
  logic          s_start = 0, s_gv = 0;
  logic [NV-1:0] s_ne = '1;
  logic [NL-1:0] s_g0 = '0, s_g1 = '0;
  logic          s_busy0, s_busy1, s_done0, s_done1;
  logic [NL-1:0] s_lv0, s_lv1, s_sv0, s_sv1;
  logic [NL*KW-1:0] s_lom0, s_lom1;
  logic [NL*VW-1:0] s_lvq0, s_lvq1, s_svq0, s_svq1;

  crrd_dispatch #(.N_PORT(NP), .N_LINK(NL), .N_MOD(NM), .N_ITER(1)) u_im0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .nonempty_i(s_ne),
    .cm_gnt_valid_i(s_gv), .cm_gnt_i(s_g0), .busy_o(s_busy0), .match_done_o(s_done0),
    .lreq_valid_o(s_lv0), .lreq_om_o(s_lom0), .lreq_voq_o(s_lvq0),
    .send_valid_o(s_sv0), .send_voq_o(s_svq0));
  crrd_dispatch #(.N_PORT(NP), .N_LINK(NL), .N_MOD(NM), .N_ITER(1)) u_im1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .nonempty_i(s_ne),
    .cm_gnt_valid_i(s_gv), .cm_gnt_i(s_g1), .busy_o(s_busy1), .match_done_o(s_done1),
    .lreq_valid_o(s_lv1), .lreq_om_o(s_lom1), .lreq_voq_o(s_lvq1),
    .send_valid_o(s_sv1), .send_voq_o(s_svq1));

  // reference state: index 0,1 switch modules, 2 standalone
  int rlp[3][NL];
  int rvp[3][NV];
  int rv[3][NL];
  int rq[3][NL];
  int rf[3][NL];
  int cmp[NL][NM];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ref_match(input int im, input logic [NV-1:0] ne, input int iters);
    int vfree[NV];
    int gl[NL];
    int v, l;
    bit taken;
    for (int i = 0; i < NV; i++) vfree[i] = 1;
    for (int i = 0; i < NL; i++) begin rv[im][i] = 0; rq[im][i] = 0; rf[im][i] = 0; end
    for (int it = 0; it < iters; it++) begin
      for (int a = 0; a < NL; a++) begin
        gl[a] = -1;
        if (rv[im][a] == 0)
          for (int i = 0; i < NV; i++) begin
            v = (rlp[im][a] + i) % NV;
            if (gl[a] < 0 && ne[v] && vfree[v] == 1) gl[a] = v;
          end
      end
      for (int b = 0; b < NV; b++) begin
        taken = 0;
        if (vfree[b] == 1)
          for (int i = 0; i < NL; i++) begin
            l = (rvp[im][b] + i) % NL;
            if (!taken && gl[l] == b) begin
              rv[im][l] = 1; rq[im][l] = b; rf[im][l] = (it == 0);
              taken = 1;
            end
          end
        if (taken) vfree[b] = 0;
      end
    end
  endtask

  task automatic ref_upd(input int im, input logic [NL-1:0] g);
    for (int l = 0; l < NL; l++)
      if (rv[im][l] == 1 && rf[im][l] == 1 && g[l]) begin
        rlp[im][l] = (rq[im][l] + 1) % NV;
        rvp[im][rq[im][l]] = (l + 1) % NL;
      end
  endtask

  task automatic cmp_req(input int im, input logic [NV-1:0] ne, input logic [NL-1:0] lv,
                         input logic [NL*KW-1:0] lom, input logic [NL*VW-1:0] lvq);
    for (int l = 0; l < NL; l++) begin
      chk("R5", $sformatf("im%0d link%0d request valid", im, l), int'(lv[l]), rv[im][l]);
      if (rv[im][l] == 1 && lv[l]) begin
        chk("R3/R4/R9", $sformatf("im%0d link%0d queue", im, l), int'(lvq[l*VW +: VW]), rq[im][l]);
        chk("R7", $sformatf("im%0d link%0d output module", im, l), int'(lom[l*KW +: KW]), rq[im][l] % NM);
        chk("R6", $sformatf("im%0d link%0d queue occupied", im, l), int'(ne[lvq[l*VW +: VW]]), 1);
      end
    end
  endtask

  task automatic run_dut(input logic [NV-1:0] ne, input logic [NL-1:0] g, input bit extra);
    int cnt;
    @(negedge clk); d_ne = ne; d_start = 1;
    @(negedge clk); d_start = extra; cnt = 0;
    while (!d_done && cnt < 20) begin
      @(negedge clk); d_start = 0; cnt++;
    end
    chk(extra ? "R2/R11" : "R2", "rounds until done", cnt, IT_DUT);
    ref_match(2, ne, IT_DUT);
    cmp_req(2, ne, d_lv, d_lom, d_lvq);
    d_gv = 1; d_g = g;
    @(negedge clk); d_gv = 0;
    chk("R2", "done strobe dropped", int'(d_done), 0);
    for (int l = 0; l < NL; l++) begin
      chk("R8", $sformatf("link%0d send valid", l), int'(d_sv[l]), (rv[2][l] == 1 && g[l]) ? 1 : 0);
      if (d_sv[l]) chk("R8", $sformatf("link%0d send queue", l), int'(d_svq[l*VW +: VW]), rq[2][l]);
    end
    ref_upd(2, g);
  endtask

  task automatic run_sw(input int slot, input int exp);
    int cnt, im, sends;
    logic [NL-1:0] lvx[2];
    logic [NL*KW-1:0] omx[2];
    logic [NL-1:0] gx[2];
    bit found;
    @(negedge clk); s_start = 1;
    @(negedge clk); s_start = 0; cnt = 0;
    while (!s_done0 && cnt < 20) begin @(negedge clk); cnt++; end
    chk("R2", $sformatf("switch slot%0d rounds", slot), cnt, 1);
    ref_match(0, '1, 1);
    ref_match(1, '1, 1);
    cmp_req(0, '1, s_lv0, s_lom0, s_lvq0);
    cmp_req(1, '1, s_lv1, s_lom1, s_lvq1);
    lvx[0] = s_lv0; lvx[1] = s_lv1; omx[0] = s_lom0; omx[1] = s_lom1;
    gx[0] = '0; gx[1] = '0;
    for (int r = 0; r < NL; r++)
      for (int j = 0; j < NM; j++) begin
        found = 0;
        for (int i = 0; i < NM; i++) begin
          im = (cmp[r][j] + i) % NM;
          if (!found && lvx[im][r] && int'(omx[im][r*KW +: KW]) == j) begin
            found = 1; gx[im][r] = 1'b1;
            if (rf[im][r] == 1) cmp[r][j] = (im + 1) % NM;
          end
        end
      end
    s_g0 = gx[0]; s_g1 = gx[1]; s_gv = 1;
    @(negedge clk); s_gv = 0;
    chk("R8", $sformatf("switch slot%0d im0 sends", slot), int'(s_sv0), int'(gx[0] & lvx[0]));
    chk("R8", $sformatf("switch slot%0d im1 sends", slot), int'(s_sv1), int'(gx[1] & lvx[1]));
    sends = $countones(s_sv0) + $countones(s_sv1);
    chk("R10", $sformatf("switch slot%0d cells sent", slot), sends, exp);
    ref_upd(0, gx[0]);
    ref_upd(1, gx[1]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [NL*VW-1:0] keep_voq;
    logic [NL-1:0]    keep_sv;
    for (int a = 0; a < 3; a++) begin
      for (int l = 0; l < NL; l++) rlp[a][l] = 0;
      for (int v = 0; v < NV; v++) rvp[a][v] = 0;
    end
    for (int r = 0; r < NL; r++) for (int j = 0; j < NM; j++) cmp[r][j] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(d_busy), 0);
    chk("R1", "done after reset", int'(d_done), 0);
    chk("R1", "requests after reset", int'(d_lv), 0);
    chk("R1", "sends after reset", int'(d_sv), 0);
    chk("R1", "switch busy after reset", int'(s_busy0 | s_busy1), 0);

    // desynchronisation on a full 2x2x2 switch
    run_sw(0, 1);
    run_sw(1, 3);
    for (int s = 2; s < 8; s++) run_sw(s, 4);

    // pointer reset state via first full slot, then refused retries
    run_dut('1, '0, 0);
    keep_voq = d_svq;
    run_dut('1, '0, 0);
    chk("R9", "refused retry repeats match", int'(d_svq), int'(keep_voq));

    // occupancy x grant sweep; pointer state carries across slots
    for (int p = 0; p < 64; p++) begin
      if (p == 21) begin
        keep_sv = d_sv; keep_voq = d_svq;
        @(negedge clk); d_gv = 1; d_g = '1;
        @(negedge clk); d_gv = 0;
        chk("R11", "idle grant leaves sends", int'(d_sv), int'(keep_sv));
        chk("R11", "idle grant leaves queues", int'(d_svq), int'(keep_voq));
        chk("R11", "idle grant leaves idle", int'(d_busy), 0);
      end
      run_dut(NV'(p ^ (p >> 2)), NL'(p >> 4), p == 37);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule